// File: doc/BRIEF.md
# Burst SRAM Address and Control Front End

This block is the synchronous front end of a flow-through burst SRAM with a 20-bit word address and an 18-bit word made of two 9-bit byte lanes. On every rising clock edge it samples two address strobes, an advance input, three chip enables and the write controls. From these it keeps a registered burst address whose two low bits come from a burst counter, and it drives a reduced-depth internal array. The array is indexed by the low address bits.

Both strobes are active low. The processor-side strobe is ignored while the master chip enable is inactive, and a cycle it starts is always a read. The controller-side strobe is accepted whatever the master chip enable does, and it samples the write controls. When neither strobe is accepted, an active advance input steps the burst. An inactive advance input holds the address, which inserts a wait state. A mode input picks linear or interleaved burst order.

Reads are flow-through: the word at the address registered on an edge is presented during the cycle that follows, with no output register in between. An active-low output enable gates the output drivers at once, without waiting for a clock edge.

Top module: `bsram_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, the device is deselected and rdata_oe_o is 0 with rdata_o all zero. The array content reads as zero.
- R2: With strb_ctl_ni low and strb_cpu_ni not accepted, the device loads addr_i only when ce_main_ni=0, ce_lo_ni=0 and ce_hi_i=1. If any of the three enables is inactive, that edge deselects the device.
- R3: With strb_cpu_ni low and ce_main_ni=0, the device loads addr_i as a read. This holds whatever gwr_ni, bwr_ni, lane_we_ni and strb_ctl_ni are, so no array write takes place on that edge.
- R4: With strb_cpu_ni low and ce_main_ni=1, the processor strobe has no effect. If strb_ctl_ni is also high, the edge behaves as a non-strobe edge.
- R5: A strobe edge with ce_hi_i=0 or ce_lo_ni=1 deselects the device. A deselected device keeps rdata_oe_o at 0 and ignores advance and write inputs on non-strobe edges.
- R6: Reads are flow-through. After an edge that loads or moves the address, rdata_o holds the stored word at that address during the following cycle.
- R7: rdata_oe_o is 1 only while the device is selected, oe_ni=0 and the last edge did not write. A change of oe_ni takes effect at once, without a clock edge.
- R8: On a selected non-strobe edge with adv_ni=0, the burst count steps by one. With order_sel_i=0 (linear), the two low address bits are (start + count) mod 4.
- R9: With order_sel_i=1 (interleaved), the two low address bits are start XOR count, where count runs 0, 1, 2, 3.
- R10: On a selected non-strobe edge with adv_ni=1, the address is held, so the same word is presented again.
- R11: gwr_ni=0 writes all 18 bits and takes priority over bwr_ni and lane_we_ni. Writes take place at the address the edge selects, both on controller-strobe edges and on selected non-strobe edges.
- R12: With gwr_ni=1 and bwr_ni=0, lane a (bits 8:0) is written when lane_we_ni[0]=0 and lane b (bits 17:9) when lane_we_ni[1]=0. The other lane keeps its old value.
- R13: A qualified edge on which no lane is enabled for writing is a read, and its data is driven in the next cycle. An edge that writes at least one lane turns the outputs off for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | External word address |
| strb_cpu_ni | input | 1 | Processor-side address strobe, active low, blocked by ce_main_ni |
| strb_ctl_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_main_ni | input | 1 | Master chip enable, active low |
| ce_lo_ni | input | 1 | Secondary chip enable, active low |
| ce_hi_i | input | 1 | Secondary chip enable, active high |
| gwr_ni | input | 1 | Global write, active low |
| bwr_ni | input | 1 | Byte-write enable, active low |
| lane_we_ni | input | 2 | Per-lane write selects, active low; bit 0 lane a, bit 1 lane b |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Read data, zero while not driven |
| rdata_oe_o | output | 1 | Output driver enable |

## Verification
The bench aims at the interplay of the two strobes with the master enable. It applies a processor strobe while the master enable is off; a design that honoured that strobe would jump to a new address. It applies both strobes at once with writes requested; a design that let the write through would corrupt memory that later reads expose. It also attempts writes to a deselected device, which a faulty design would store.

It walks bursts from every start offset in both orders and inserts wait states. A wrong wrap or XOR shows up as a misordered word, and a wrong hold shows up as a skipped word. Lane writes with and without the global write check priority and lane isolation. A design that got either wrong would leave a wrong half-word in the array. A randomised phase compares every cycle against a behavioural model.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DESEL = 2'd2
  } act_e;
endpackage

// File: rtl/bsram_cmd_dec.sv
module bsram_cmd_dec
  import bsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strb_cpu_ni,
  input  logic             strb_ctl_ni,
  input  logic             adv_ni,
  input  logic             ce_main_ni,
  input  logic             ce_lo_ni,
  input  logic             ce_hi_i,
  input  logic             gwr_ni,
  input  logic             bwr_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             sel_i,
  output act_e             act_o,
  output logic             adv_o,
  output logic [LANES-1:0] we_o
);
  logic cpu_ok, ctl_ok, ce_all;
  logic [LANES-1:0] req_mask;

  assign cpu_ok = !strb_cpu_ni && !ce_main_ni;
  assign ctl_ok = !strb_ctl_ni;
  assign ce_all = !ce_main_ni && !ce_lo_ni && ce_hi_i;

  always_comb begin
    if (cpu_ok || ctl_ok) act_o = ce_all ? ACT_LOAD : ACT_DESEL;
    else                  act_o = ACT_HOLD;
  end

  // global write wins over lane selects
  assign req_mask = !gwr_ni ? {LANES{1'b1}} : (!bwr_ni ? ~lane_we_ni : '0);

  always_comb begin
    we_o = '0;
    if (!cpu_ok) begin
      if (act_o == ACT_LOAD || (act_o == ACT_HOLD && sel_i)) we_o = req_mask;
    end
  end

  assign adv_o = (act_o == ACT_HOLD) && sel_i && !adv_ni;

  // R3
  cpu_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && !ce_main_ni) |-> (we_o == '0));
  // R5
  desel_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_cpu_ni && strb_ctl_ni && !sel_i) |-> (we_o == '0 && !adv_o));
endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] start_i,
  input  logic          adv_i,
  input  logic          interleave_i,
  output logic [CW-1:0] offs_o,
  output logic [CW-1:0] offs_nxt_o
);
  logic [CW-1:0] start_q, cnt_q, start_n, cnt_n;

  always_comb begin
    start_n = start_q;
    cnt_n   = cnt_q;
    if (load_i) begin
      start_n = start_i;
      cnt_n   = '0;
    end else if (adv_i) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_n;
      cnt_q   <= cnt_n;
    end
  end

  generate
    if (CW > 0) begin : g_order
      assign offs_nxt_o = interleave_i ? (start_n ^ cnt_n) : (start_n + cnt_n);
      assign offs_o     = interleave_i ? (start_q ^ cnt_q) : (start_q + cnt_q);
    end
  endgenerate

  // R8
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> ($stable(cnt_q) && $stable(start_q)));
  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0 && start_q == $past(start_i)));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int AW     = 6,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH  = 1 << AW;
  localparam int LANE_W = DATA_W / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i[l]) begin
        mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];

    // R12
    lane_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i[l] && raddr_i == waddr_i) |=>
        (rdata_o[l*LANE_W +: LANE_W] == $past(rdata_o[l*LANE_W +: LANE_W]) || raddr_i != $past(raddr_i)));
  end
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 18,
  parameter int LANES   = 2,
  parameter int BURST_W = 2,
  parameter int ARR_AW  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_cpu_ni,
  input  logic              strb_ctl_ni,
  input  logic              adv_ni,
  input  logic              ce_main_ni,
  input  logic              ce_lo_ni,
  input  logic              ce_hi_i,
  input  logic              gwr_ni,
  input  logic              bwr_ni,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic              order_sel_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  act_e               act;
  logic               adv, sel_q, wr_q, load;
  logic [LANES-1:0]   arr_we;
  logic [HI_W-1:0]    addr_hi_q, addr_hi_n;
  logic [BURST_W-1:0] offs, offs_nxt;
  logic [ADDR_W-1:0]  cur_addr, eff_addr;
  logic [DATA_W-1:0]  arr_rd;

  bsram_cmd_dec #(.LANES(LANES)) u_dec (
    .clk_i, .rst_ni, .strb_cpu_ni, .strb_ctl_ni, .adv_ni, .ce_main_ni,
    .ce_lo_ni, .ce_hi_i, .gwr_ni, .bwr_ni, .lane_we_ni,
    .sel_i(sel_q), .act_o(act), .adv_o(adv), .we_o(arr_we)
  );

  assign load = (act == ACT_LOAD);

  bsram_burst_ctr #(.CW(BURST_W)) u_ctr (
    .clk_i, .rst_ni, .load_i(load), .start_i(addr_i[BURST_W-1:0]),
    .adv_i(adv), .interleave_i(order_sel_i),
    .offs_o(offs), .offs_nxt_o(offs_nxt)
  );

  assign addr_hi_n = load ? addr_i[ADDR_W-1:BURST_W] : addr_hi_q;
  assign eff_addr  = {addr_hi_n, offs_nxt};
  assign cur_addr  = {addr_hi_q, offs};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_hi_q <= '0;
      sel_q     <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      addr_hi_q <= addr_hi_n;
      wr_q      <= |arr_we;
      if (load)                 sel_q <= 1'b1;
      else if (act == ACT_DESEL) sel_q <= 1'b0;
    end
  end

  bsram_array #(.AW(ARR_AW), .DATA_W(DATA_W), .LANES(LANES)) u_arr (
    .clk_i, .rst_ni, .we_i(arr_we), .waddr_i(eff_addr[ARR_AW-1:0]),
    .wdata_i, .raddr_i(cur_addr[ARR_AW-1:0]), .rdata_o(arr_rd)
  );

  // flow-through, async output enable
  assign rdata_oe_o = sel_q && !oe_ni && !wr_q;
  assign rdata_o    = rdata_oe_o ? arr_rd : '0;

  // R5
  desel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_ctl_ni && (ce_main_ni || ce_lo_ni || !ce_hi_i)) |=> !rdata_oe_o);
  // R13
  wr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arr_we) |=> !rdata_oe_o);
  // R4
  cpu_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && ce_main_ni && strb_ctl_ni) |=> $stable(sel_q) && $stable(addr_hi_q));
  // R3
  cpu_load_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && !ce_main_ni && !ce_lo_ni && ce_hi_i && !oe_ni) |=> (rdata_oe_o || oe_ni));
endmodule

// File: tb/bsram_ctrl_tb_top.sv
module bsram_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr_i = '0;
  logic        strb_cpu_ni = 1'b1, strb_ctl_ni = 1'b1, adv_ni = 1'b1;
  logic        ce_main_ni = 1'b0, ce_lo_ni = 1'b0, ce_hi_i = 1'b1;
  logic        gwr_ni = 1'b1, bwr_ni = 1'b1;
  logic [1:0]  lane_we_ni = 2'b11;
  logic        order_sel_i = 1'b0, oe_ni = 1'b0;
  logic [17:0] wdata_i = '0;
  logic [17:0] rdata_o;
  logic        rdata_oe_o;

  int n_checks = 0, n_fail = 0;

  // behavioural model state
  logic [17:0] m_mem [64];
  bit          m_sel, m_wr;
  int          m_base, m_start, m_cnt;

  always #5 clk_i = ~clk_i;

  bsram_ctrl dut_i (
    .clk_i, .rst_ni, .addr_i, .strb_cpu_ni, .strb_ctl_ni, .adv_ni, .ce_main_ni,
    .ce_lo_ni, .ce_hi_i, .gwr_ni, .bwr_ni, .lane_we_ni, .order_sel_i, .oe_ni,
    .wdata_i, .rdata_o, .rdata_oe_o
  );

  function automatic int low_bits(int s, int c, bit il);
    return il ? ((s ^ c) & 3) : ((s + c) & 3);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_sel = 0; m_wr = 0; m_base = 0; m_start = 0; m_cnt = 0;
  endtask

  task automatic model_edge();
    bit cpu, ctl, ce_all;
    logic [1:0] mask;
    int idx;
    cpu    = !strb_cpu_ni && !ce_main_ni;
    ctl    = !strb_ctl_ni;
    ce_all = !ce_main_ni && !ce_lo_ni && ce_hi_i;
    if (!gwr_ni)      mask = 2'b11;
    else if (!bwr_ni) mask = ~lane_we_ni;
    else              mask = 2'b00;
    if (cpu || ctl) begin
      if (ce_all) begin
        m_sel = 1; m_base = int'(addr_i) & ~3; m_start = int'(addr_i) & 3; m_cnt = 0;
        if (cpu) mask = 2'b00;
      end else begin
        m_sel = 0; mask = 2'b00;
      end
    end else if (m_sel) begin
      if (!adv_ni) m_cnt = (m_cnt + 1) & 3;
    end else begin
      mask = 2'b00;
    end
    idx = (m_base | low_bits(m_start, m_cnt, order_sel_i)) & 63;
    if (mask[0]) m_mem[idx][8:0]  = wdata_i[8:0];
    if (mask[1]) m_mem[idx][17:9] = wdata_i[17:9];
    m_wr = (mask != 2'b00);
  endtask

  task automatic compare(input string tag);
    bit exp_oe;
    logic [17:0] exp_d;
    int idx;
    idx    = (m_base | low_bits(m_start, m_cnt, order_sel_i)) & 63;
    exp_oe = m_sel && !oe_ni && !m_wr;
    exp_d  = exp_oe ? m_mem[idx] : 18'h0;
    n_checks++;
    if (rdata_oe_o !== exp_oe || rdata_o !== exp_d) begin
      n_fail++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, rdata_oe_o, rdata_o, exp_oe, exp_d);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle();
    strb_cpu_ni = 1; strb_ctl_ni = 1; adv_ni = 1;
    ce_main_ni = 0; ce_lo_ni = 0; ce_hi_i = 1;
    gwr_ni = 1; bwr_ni = 1; lane_we_ni = 2'b11;
  endtask

  task automatic ctl_write(input logic [19:0] a, input logic [17:0] d, input string tag);
    idle(); strb_ctl_ni = 0; addr_i = a; gwr_ni = 0; wdata_i = d;
    step(tag);
    idle();
  endtask

  task automatic cpu_read(input logic [19:0] a, input string tag);
    idle(); strb_cpu_ni = 0; addr_i = a;
    step(tag);
    idle();
  endtask

  task automatic advance(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      idle(); adv_ni = 0;
      step(tag);
    end
    idle();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    compare("R1 during reset");
    rst_ni = 1;
    @(negedge clk_i);
    compare("R1 after reset");
    cpu_read(20'h00009, "R1 array zero after reset");

    // fill a group of four with a global write burst
    ctl_write(20'h00004, 18'h3ABCD, "R11 global write");
    for (int i = 0; i < 3; i++) begin
      idle(); adv_ni = 0; gwr_ni = 0; wdata_i = 18'h01111 * (i + 2);
      step("R11 burst write");
    end
    idle();

    // linear read from every start offset, with waits
    for (int s = 0; s < 4; s++) begin
      cpu_read(20'h00004 + 20'(s), "R6 flow-through load");
      advance(1, "R8 linear advance");
      step("R10 wait state");
      advance(3, "R8 linear wrap");
    end

    // interleaved order
    order_sel_i = 1;
    for (int s = 0; s < 4; s++) begin
      cpu_read(20'h00004 + 20'(s), "R9 interleaved load");
      advance(2, "R9 interleaved advance");
      step("R10 interleaved hold");
      advance(2, "R9 interleaved wrap");
    end
    order_sel_i = 0;

    // byte lanes
    ctl_write(20'h00010, 18'h3FFFF, "R11 setup");
    idle(); strb_ctl_ni = 0; addr_i = 20'h00010; bwr_ni = 0; lane_we_ni = 2'b10; wdata_i = 18'h00000;
    step("R12 lane a write");
    idle(); strb_ctl_ni = 0; addr_i = 20'h00011; bwr_ni = 0; lane_we_ni = 2'b01; wdata_i = 18'h155AA;
    step("R12 lane b write");
    cpu_read(20'h00010, "R12 lane a readback");
    advance(1, "R12 lane b readback");
    // global write priority over lane selects
    idle(); strb_ctl_ni = 0; addr_i = 20'h00012; gwr_ni = 0; bwr_ni = 0; lane_we_ni = 2'b11; wdata_i = 18'h2D2D2;
    step("R11 global priority");
    idle(); step("R11 hold after write");
    cpu_read(20'h00012, "R11 priority readback");
    // byte enable with no lanes is a read
    idle(); strb_ctl_ni = 0; addr_i = 20'h00012; bwr_ni = 0; lane_we_ni = 2'b11; wdata_i = 18'h0;
    step("R13 no lane read");
    idle(); strb_ctl_ni = 0; addr_i = 20'h00004; wdata_i = 18'h12345;
    step("R13 plain ctl read");

    // processor strobe never writes, even with both strobes
    idle(); strb_cpu_ni = 0; addr_i = 20'h00005; gwr_ni = 0; wdata_i = 18'h00000;
    step("R3 cpu strobe ignores write");
    idle(); strb_cpu_ni = 0; strb_ctl_ni = 0; addr_i = 20'h00006; gwr_ni = 0; wdata_i = 18'h00000;
    step("R3 both strobes read");
    cpu_read(20'h00005, "R3 memory intact");

    // blocked processor strobe
    idle(); strb_cpu_ni = 0; ce_main_ni = 1; addr_i = 20'h00010;
    step("R4 blocked strobe holds");
    idle(); strb_cpu_ni = 0; ce_main_ni = 1; adv_ni = 0; addr_i = 20'h00010;
    step("R4 blocked strobe advance");
    idle();

    // deselects
    idle(); strb_ctl_ni = 0; ce_main_ni = 1; addr_i = 20'h00008;
    step("R2 ctl deselect by main enable");
    idle(); adv_ni = 0; gwr_ni = 0; wdata_i = 18'h3FFFF;
    step("R5 deselected ignores write");
    idle(); strb_ctl_ni = 0; ce_lo_ni = 1; addr_i = 20'h00008;
    step("R2 ctl deselect by low enable");
    cpu_read(20'h00008, "R5 reselect data intact");
    idle(); strb_cpu_ni = 0; ce_hi_i = 0; addr_i = 20'h00004;
    step("R5 cpu deselect by high enable");
    idle(); step("R5 stays deselected");

    // asynchronous output enable
    cpu_read(20'h00004, "R7 setup");
    #2 oe_ni = 1; #1 compare("R7 oe off mid-cycle");
    #1 oe_ni = 0; #1 compare("R7 oe on mid-cycle");
    @(negedge clk_i);

    // randomised phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      strb_cpu_ni = (r[2:0] != 0);
      strb_ctl_ni = (r[5:3] != 0);
      adv_ni      = r[6];
      ce_main_ni  = (r[9:7] == 0);
      ce_lo_ni    = (r[12:10] == 0);
      ce_hi_i     = (r[15:13] != 0);
      gwr_ni      = (r[17:16] != 0);
      bwr_ni      = r[18];
      lane_we_ni  = r[20:19];
      order_sel_i = (i >= 200);
      addr_i      = {12'(r[31:24]), 8'(r[31:24])};
      wdata_i     = 18'($urandom);
      oe_ni       = (r[23:21] == 0);
      step("R6 random model compare");
    end
    idle(); oe_ni = 0;

    finish_run();
  end
endmodule